// File: doc/BRIEF.md
# Unaligned Load Byte-Merge Unit

This block builds the register result of the two partial-word loads that let software read a 32-bit value from any byte address in two steps. For each request it takes the naturally aligned memory word that encloses the effective address, the low two address bits, a direction select and the current value of the destination register. It moves the addressed part of the memory word into either the upper end or the lower end of the register. Lanes that the operation does not replace keep their old register value.

The result is registered and appears one cycle after a valid request, together with a per-lane write mask and the destination index. A back-to-back request to the same destination takes the registered result as its base instead of the register-file value. This forwarding lets an upper-fill and lower-fill pair, issued one after the other, assemble a complete unaligned word. A parameter selects big- or little-endian byte numbering.

Top module: `unaligned_load_merge`

## Requirements
- R1: Big-endian mode (memory byte i sits at `req_word_i[31-8i -: 8]`): an upper-fill request (`req_dir_i`=0) with offset k writes memory bytes k..3 into the 4-k most significant register lanes, with byte k at bits [31:24].
- R2: Every register lane that a request does not replace keeps the value of its base operand. The base operand is `req_reg_i` unless R9 applies.
- R3: Big-endian mode: a lower-fill request (`req_dir_i`=1) with offset k writes memory bytes 0..k into the k+1 least significant lanes, with byte k at bits [7:0].
- R4: Little-endian mode (memory byte i sits at `req_word_i[8i+7:8i]`): an upper-fill request at offset k writes bytes 0..k into the k+1 top lanes, with byte k at [31:24]. A lower-fill request at offset k writes bytes k..3 into the 4-k bottom lanes, with byte k at [7:0].
- R5: Bit j of `res_mask_o` is set exactly when lane j (bits 8j+7:8j) was replaced. Upper-fill always sets bit 3 and lower-fill always sets bit 0. The mask is all ones for upper-fill at k=0 and lower-fill at k=3 in big-endian mode, and for upper-fill at k=3 and lower-fill at k=0 in little-endian mode.
- R6: Two back-to-back requests to one destination rebuild the 32-bit value stored at bytes a..a+3 for any a. In big-endian mode these are upper-fill at a, then lower-fill at a+3. In little-endian mode they are lower-fill at a, then upper-fill at a+3.
- R7: `res_valid_o` equals `req_valid_i` delayed by one clock, and a request's data, mask and destination appear in that same cycle.
- R8: A cycle without `req_valid_i` leaves `res_data_o`, `res_mask_o` and `res_dst_o` unchanged, whatever the other inputs hold.
- R9: When `req_valid_i` is high, `res_valid_o` is high and `res_dst_o` equals `req_dst_i`, the base operand is `res_data_o` and `req_reg_i` is ignored.
- R10: While `rst_ni` is low, `res_valid_o`, `res_data_o`, `res_mask_o` and `res_dst_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Request strobe |
| req_dir_i | input | 1 | 0 = fill upper lanes, 1 = fill lower lanes |
| req_off_i | input | 2 | Effective address bits [1:0] |
| req_word_i | input | 32 | Aligned memory word containing the address |
| req_reg_i | input | 32 | Current destination register value |
| req_dst_i | input | 5 | Destination register index |
| res_valid_o | output | 1 | Result valid |
| res_data_o | output | 32 | Merged register value |
| res_mask_o | output | 4 | Lanes replaced by memory bytes |
| res_dst_o | output | 5 | Destination index of the result |

## Verification
The assertions assume a clean reset with `req_valid_i` held low. They also assume that the caller provides `req_reg_i` as the architectural register value only when no forwarding match exists. The kept-lane properties compare against `req_reg_i` or against the previous `res_data_o`, depending on whether the destination matched the previous cycle. The stimulus assigns a fresh destination index to every request in the sweep. It reuses an index only in the deliberate forwarding and pair-rebuild sequences, where `req_reg_i` carries a garbage value. Any leak of that value into kept lanes is therefore visible at the outputs.

// File: rtl/ulm_pkg.sv
package ulm_pkg;
  localparam int unsigned LANE_W = 8;

  typedef enum logic {
    FILL_UPPER = 1'b0,
    FILL_LOWER = 1'b1
  } fill_dir_e;
endpackage

// File: rtl/ulm_lane_ctrl.sv
module ulm_lane_ctrl
  import ulm_pkg::*;
#(
  parameter bit          BIG_ENDIAN = 1'b1,
  parameter int unsigned LANES      = 4,
  parameter int unsigned OFF_W      = $clog2(LANES)
) (
  input  fill_dir_e          dir_i,
  input  logic [OFF_W-1:0]   off_i,
  output logic               shl_o,
  output logic [OFF_W-1:0]   amt_o,
  output logic [LANES-1:0]   mask_o
);
  localparam logic [OFF_W-1:0] TOP = OFF_W'(LANES - 1);

  logic lower;
  assign lower = (dir_i == FILL_LOWER);
  assign shl_o = ~lower;

  // lane shift distance; endianness mirrors which offset end is anchored
  generate
    if (BIG_ENDIAN) begin : g_be
      assign amt_o = lower ? (TOP - off_i) : off_i;
    end else begin : g_le
      assign amt_o = lower ? off_i : (TOP - off_i);
    end
  endgenerate

  generate
    for (genvar j = 0; j < LANES; j++) begin : g_mask
      localparam logic [OFF_W-1:0] IDX = OFF_W'(j);
      assign mask_o[j] = shl_o ? (IDX >= amt_o) : (IDX <= (TOP - amt_o));
    end
  endgenerate
endmodule

// File: rtl/ulm_aligner.sv
module ulm_aligner #(
  parameter int unsigned LANES  = 4,
  parameter int unsigned LANE_W = 8,
  parameter int unsigned OFF_W  = $clog2(LANES)
) (
  input  logic [LANES*LANE_W-1:0] word_i,
  input  logic                    shl_i,
  input  logic [OFF_W-1:0]        amt_i,
  output logic [LANES*LANE_W-1:0] data_o
);
  generate
    for (genvar j = 0; j < LANES; j++) begin : g_lane
      logic [LANE_W-1:0] up_c [LANES];
      logic [LANE_W-1:0] dn_c [LANES];
      for (genvar s = 0; s < LANES; s++) begin : g_src
        if (j >= s) begin : g_up
          assign up_c[s] = word_i[(j-s)*LANE_W +: LANE_W];
        end else begin : g_up0
          assign up_c[s] = '0;
        end
        if (j + s < LANES) begin : g_dn
          assign dn_c[s] = word_i[(j+s)*LANE_W +: LANE_W];
        end else begin : g_dn0
          assign dn_c[s] = '0;
        end
      end
      assign data_o[j*LANE_W +: LANE_W] = shl_i ? up_c[amt_i] : dn_c[amt_i];
    end
  endgenerate
endmodule

// File: rtl/ulm_merge.sv
module ulm_merge #(
  parameter int unsigned LANES  = 4,
  parameter int unsigned LANE_W = 8
) (
  input  logic [LANES*LANE_W-1:0] new_i,
  input  logic [LANES*LANE_W-1:0] base_i,
  input  logic [LANES-1:0]        mask_i,
  output logic [LANES*LANE_W-1:0] data_o
);
  generate
    for (genvar j = 0; j < LANES; j++) begin : g_lane
      assign data_o[j*LANE_W +: LANE_W] =
        mask_i[j] ? new_i[j*LANE_W +: LANE_W] : base_i[j*LANE_W +: LANE_W];
    end
  endgenerate
endmodule

// File: rtl/unaligned_load_merge.sv
module unaligned_load_merge
  import ulm_pkg::*;
#(
  parameter bit          BIG_ENDIAN = 1'b1,
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned DST_W      = 5
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           req_valid_i,
  input  logic                           req_dir_i,
  input  logic [$clog2(DATA_W/8)-1:0]    req_off_i,
  input  logic [DATA_W-1:0]              req_word_i,
  input  logic [DATA_W-1:0]              req_reg_i,
  input  logic [DST_W-1:0]               req_dst_i,
  output logic                           res_valid_o,
  output logic [DATA_W-1:0]              res_data_o,
  output logic [DATA_W/8-1:0]            res_mask_o,
  output logic [DST_W-1:0]               res_dst_o
);
  localparam int unsigned LANES = DATA_W / LANE_W;
  localparam int unsigned OFF_W = $clog2(LANES);

  logic               shl;
  logic [OFF_W-1:0]   amt;
  logic [LANES-1:0]   mask;
  logic [DATA_W-1:0]  aligned;
  logic [DATA_W-1:0]  base;
  logic [DATA_W-1:0]  merged;
  logic               fwd_hit;

  ulm_lane_ctrl #(
    .BIG_ENDIAN (BIG_ENDIAN),
    .LANES      (LANES),
    .OFF_W      (OFF_W)
  ) u_ctrl (
    .dir_i  (fill_dir_e'(req_dir_i)),
    .off_i  (req_off_i),
    .shl_o  (shl),
    .amt_o  (amt),
    .mask_o (mask)
  );

  ulm_aligner #(
    .LANES  (LANES),
    .LANE_W (LANE_W),
    .OFF_W  (OFF_W)
  ) u_align (
    .word_i (req_word_i),
    .shl_i  (shl),
    .amt_i  (amt),
    .data_o (aligned)
  );

  // forward the in-flight result when the destination repeats
  assign fwd_hit = res_valid_o && (res_dst_o == req_dst_i);
  assign base    = fwd_hit ? res_data_o : req_reg_i;

  ulm_merge #(
    .LANES  (LANES),
    .LANE_W (LANE_W)
  ) u_merge (
    .new_i  (aligned),
    .base_i (base),
    .mask_i (mask),
    .data_o (merged)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_valid_o <= 1'b0;
      res_data_o  <= '0;
      res_mask_o  <= '0;
      res_dst_o   <= '0;
    end else begin
      res_valid_o <= req_valid_i;
      if (req_valid_i) begin
        res_data_o <= merged;
        res_mask_o <= mask;
        res_dst_o  <= req_dst_i;
      end
    end
  end
endmodule

// File: rtl/ulm_checker.sv
module ulm_checker #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned LANES  = 4,
  parameter int unsigned LANE_W = 8,
  parameter int unsigned DST_W  = 5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic              req_dir_i,
  input logic [DATA_W-1:0] req_word_i,
  input logic [DATA_W-1:0] req_reg_i,
  input logic [DST_W-1:0]  req_dst_i,
  input logic              res_valid_o,
  input logic [DATA_W-1:0] res_data_o,
  input logic [LANES-1:0]  res_mask_o,
  input logic [DST_W-1:0]  res_dst_o
);
  logic [DATA_W-1:0] keep_bits;
  logic [LANES-1:0]  inv_mask;
  logic              hit;

  generate
    for (genvar l = 0; l < LANES; l++) begin : g_bits
      assign keep_bits[l*LANE_W +: LANE_W] = {LANE_W{~res_mask_o[l]}};
    end
  endgenerate

  assign inv_mask = ~res_mask_o;
  assign hit      = res_valid_o && (res_dst_o == req_dst_i);

  AST_VALID_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> res_valid_o);                                                     // R7
  AST_VALID_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !res_valid_o);                                                   // R7
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> ($stable(res_data_o) && $stable(res_mask_o) && $stable(res_dst_o))); // R8
  AST_MASK_SHAPE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |-> ((res_mask_o != '0) &&
      (((res_mask_o & (res_mask_o + LANES'(1))) == '0) ||
       ((inv_mask & (inv_mask + LANES'(1))) == '0))));                                // R5
  AST_UPPER_TOUCHES_MSB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !req_dir_i) |=> res_mask_o[LANES-1]);                             // R5
  AST_LOWER_TOUCHES_LSB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_dir_i) |=> res_mask_o[0]);                                    // R5
  AST_FULL_PASSTHRU: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> ((res_mask_o != '1) || (res_data_o == $past(req_word_i))));       // R1
  AST_KEEP_REG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !hit) |=> (((res_data_o ^ $past(req_reg_i)) & keep_bits) == '0)); // R2
  AST_KEEP_FWD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && hit) |=> (((res_data_o ^ $past(res_data_o)) & keep_bits) == '0)); // R9
  AST_DST_TRACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> (res_dst_o == $past(req_dst_i)));                                 // R7
endmodule

bind unaligned_load_merge ulm_checker #(
  .DATA_W (DATA_W),
  .LANES  (LANES),
  .LANE_W (ulm_pkg::LANE_W),
  .DST_W  (DST_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_dir_i   (req_dir_i),
  .req_word_i  (req_word_i),
  .req_reg_i   (req_reg_i),
  .req_dst_i   (req_dst_i),
  .res_valid_o (res_valid_o),
  .res_data_o  (res_data_o),
  .res_mask_o  (res_mask_o),
  .res_dst_o   (res_dst_o)
);

// File: tb/unaligned_load_merge_tb.sv
`timescale 1ns/1ps
module unaligned_load_merge_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic        dir  [2];
  logic [1:0]  off  [2];
  logic [31:0] word [2];
  logic [31:0] reg_v = '0;
  logic [4:0]  dst = '0;
  logic        rv   [2];
  logic [31:0] rd   [2];
  logic [3:0]  rm   [2];
  logic [4:0]  rdst [2];

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;
  logic [4:0] dst_ctr = 5'd1;

  always #2 clk = ~clk;

  // index 0 = little-endian, index 1 = big-endian
  unaligned_load_merge #(.BIG_ENDIAN(1'b0)) u_dut_le (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(valid), .req_dir_i(dir[0]),
    .req_off_i(off[0]), .req_word_i(word[0]), .req_reg_i(reg_v), .req_dst_i(dst),
    .res_valid_o(rv[0]), .res_data_o(rd[0]), .res_mask_o(rm[0]), .res_dst_o(rdst[0]));

  unaligned_load_merge #(.BIG_ENDIAN(1'b1)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(valid), .req_dir_i(dir[1]),
    .req_off_i(off[1]), .req_word_i(word[1]), .req_reg_i(reg_v), .req_dst_i(dst),
    .res_valid_o(rv[1]), .res_data_o(rd[1]), .res_mask_o(rm[1]), .res_dst_o(rdst[1]));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // byte-array reference model
  function automatic void ref_op(input bit be, input bit lower, input int k,
                                 input logic [31:0] w, input logic [31:0] base,
                                 output logic [31:0] d, output logic [3:0] m);
    logic [7:0] mem [4];
    logic [7:0] ln  [4];
    for (int i = 0; i < 4; i++) begin
      mem[i] = be ? w[31-8*i -: 8] : w[8*i +: 8];
      ln[i]  = base[8*i +: 8];
    end
    m = '0;
    if (be && !lower)
      for (int n = 0; n <= 3-k; n++) begin ln[3-n] = mem[k+n]; m[3-n] = 1'b1; end
    else if (be && lower)
      for (int n = 0; n <= k; n++) begin ln[n] = mem[k-n]; m[n] = 1'b1; end
    else if (!be && !lower)
      for (int n = 0; n <= k; n++) begin ln[3-n] = mem[k-n]; m[3-n] = 1'b1; end
    else
      for (int n = 0; n <= 3-k; n++) begin ln[n] = mem[k+n]; m[n] = 1'b1; end
    d = {ln[3], ln[2], ln[1], ln[0]};
  endfunction

  task automatic issue(input logic d0, input logic [1:0] o0, input logic [31:0] w0,
                       input logic d1, input logic [1:0] o1, input logic [31:0] w1,
                       input logic [31:0] r, input logic [4:0] ds);
    @(negedge clk);
    valid = 1'b1;
    dir[0] = d0; off[0] = o0; word[0] = w0;
    dir[1] = d1; off[1] = o1; word[1] = w1;
    reg_v = r; dst = ds;
    @(posedge clk);
    #1;
  endtask

  task automatic go_idle();
    @(negedge clk);
    valid = 1'b0;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog R7 actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] ed, ed2, base_be, base_le;
    logic [3:0]  em, em2;
    logic [31:0] pat_w [3];
    logic [31:0] pat_r [3];
    pat_w[0] = 32'h11223344; pat_w[1] = 32'hA5C3E187; pat_w[2] = 32'h0F1E2D3C;
    pat_r[0] = 32'hDEADBEEF; pat_r[1] = 32'h00000000; pat_r[2] = 32'h96877869;
    for (int i = 0; i < 2; i++) begin dir[i] = 1'b0; off[i] = '0; word[i] = '0; end

    // R10: reset state
    repeat (3) @(posedge clk);
    #1;
    for (int i = 0; i < 2; i++) begin
      chk("R10 valid", 32'(rv[i]), 32'd0);
      chk("R10 data", rd[i], 32'd0);
      chk("R10 mask", 32'(rm[i]), 32'd0);
      chk("R10 dst", 32'(rdst[i]), 32'd0);
    end
    @(negedge clk);
    rst_n = 1'b1;

    // R1 R2 R3 R4 R5 R7: full sweep, fresh destination each request
    for (int p = 0; p < 3; p++) begin
      for (int op = 0; op < 2; op++) begin
        for (int k = 0; k < 4; k++) begin
          dst_ctr = dst_ctr + 5'd1;
          issue(op[0], 2'(k), pat_w[p], op[0], 2'(k), pat_w[p], pat_r[p], dst_ctr);
          for (int e = 0; e < 2; e++) begin
            ref_op(e[0], op[0], k, pat_w[p], pat_r[p], ed, em);
            chk(e ? (op ? "R3 R2 data" : "R1 R2 data") : "R4 R2 data", rd[e], ed);
            chk("R5 mask", 32'(rm[e]), 32'(em));
            chk("R7 valid", 32'(rv[e]), 32'd1);
            chk("R7 dst", 32'(rdst[e]), 32'(dst_ctr));
          end
        end
      end
    end

    // R7 R8: idle cycle with changed inputs leaves outputs as they were
    ed = rd[1]; ed2 = rd[0]; em = rm[1]; em2 = rm[0];
    @(negedge clk);
    valid = 1'b0;
    word[0] = 32'hFFFFFFFF; word[1] = 32'hFFFFFFFF; reg_v = 32'h12345678;
    off[0] = 2'd1; off[1] = 2'd2; dst = 5'd30;
    @(posedge clk);
    #1;
    chk("R7 idle valid be", 32'(rv[1]), 32'd0);
    chk("R7 idle valid le", 32'(rv[0]), 32'd0);
    chk("R8 hold data be", rd[1], ed);
    chk("R8 hold data le", rd[0], ed2);
    chk("R8 hold mask be", 32'(rm[1]), 32'(em));
    chk("R8 hold mask le", 32'(rm[0]), 32'(em2));
    chk("R8 hold dst", 32'(rdst[1]), 32'(dst_ctr));

    // R9: forwarding of the previous result to the same destination
    issue(1'b0, 2'd1, 32'hAABBCCDD, 1'b0, 2'd1, 32'hAABBCCDD, 32'h01020304, 5'd7);
    base_le = rd[0]; base_be = rd[1];
    issue(1'b1, 2'd1, 32'h55667788, 1'b1, 2'd1, 32'h55667788, 32'hEEEEEEEE, 5'd7);
    ref_op(1'b1, 1'b1, 1, 32'h55667788, base_be, ed, em);
    chk("R9 fwd be", rd[1], ed);
    ref_op(1'b0, 1'b1, 1, 32'h55667788, base_le, ed, em);
    chk("R9 fwd le", rd[0], ed);
    go_idle();

    // R6: every start offset, four byte patterns, both byte orders
    for (int a = 0; a < 4; a++) begin
      for (int q = 0; q < 4; q++) begin
        logic [7:0]  m8 [8];
        logic [31:0] wbe [2];
        logic [31:0] wle [2];
        int k2;
        for (int i = 0; i < 8; i++) m8[i] = 8'(q*59 + i*23 + 7);
        for (int n = 0; n < 2; n++) begin
          wbe[n] = {m8[4*n], m8[4*n+1], m8[4*n+2], m8[4*n+3]};
          wle[n] = {m8[4*n+3], m8[4*n+2], m8[4*n+1], m8[4*n]};
        end
        k2 = (a + 3) % 4;
        issue(1'b1, 2'(a), wle[0], 1'b0, 2'(a), wbe[0], 32'hC0C0C0C0, 5'd3);
        issue(1'b0, 2'(k2), wle[(a+3)/4], 1'b1, 2'(k2), wbe[(a+3)/4], 32'h3C3C3C3C, 5'd3);
        chk("R6 rebuild be", rd[1], {m8[a], m8[a+1], m8[a+2], m8[a+3]});
        chk("R6 rebuild le", rd[0], {m8[a+3], m8[a+2], m8[a+1], m8[a]});
      end
    end
    go_idle();
    repeat (2) @(posedge clk);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule